// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block gathers interrupt requests from numbered sources 1 to 31 and drives one active-low interrupt line to a processor. Each source has a stored mode and a stored vector word. The mode holds an enable bit, an exclusion bit, a trigger type and a 3-bit priority. A level-type source counts as pending while its input is high. An edge-type source latches a request on a rising input edge and keeps it until the request is acknowledged.

The interrupt line asserts as soon as any enabled source is pending, without waiting for a priority decision. The choice of winner is made only when software strobes a vector read. At that moment the block picks the eligible source with the highest priority, breaking ties toward the lower source number. It returns that source's vector word, records the source as the current interrupt and treats the read as the acknowledgment.

While an interrupt is current, only sources whose priority is strictly above the current priority are eligible. The line stays high unless such a source is pending. An end-of-interrupt strobe clears the current interrupt.

Top module: `irq_vec_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after its release, `irq_n` is 1, `cur_valid` is 0 and `vec_data` holds the default vector 0xFFFF_0000.
- R2: A write with `cfg_kind`=0 stores `cfg_wdata[5:0]` as the mode of source `cfg_idx`, with these fields: bit 5 is enable, bit 4 is exclude, bit 3 is the trigger type (1 for edge, 0 for level) and bits 2:0 are the priority, where 7 is the highest. A write with `cfg_kind`=1 stores `cfg_wdata` as that source's vector word. All modes and vectors reset to 0.
- R3: For a level source, `irq_n` goes low at the second rising clock edge after the input rises, which is within 3.5 cycles.
- R4: An edge source is latched on a rising input edge. `irq_n` goes low at the third rising clock edge after that, which is within 4.5 cycles, and it stays low after the input falls again.
- R5: A vector read strobe (`vec_rd` high for one cycle) selects the eligible source with the highest priority. Its vector word appears on `vec_data` after that clock edge.
- R6: Among eligible sources of equal priority, the source with the lowest number wins.
- R7: The winner is decided from the requests pending at the read. A source that became pending after `irq_n` fell is included.
- R8: A read that finds a winner sets `cur_valid`, `cur_src` and `cur_prio` to the winning source and its priority. If the winner is an edge source, its latched request is cleared.
- R9: A read that finds no eligible source returns the default vector 0xFFFF_0000 and leaves the current-interrupt state unchanged.
- R10: While `cur_valid` is 1, only sources with priority strictly above `cur_prio` are eligible. `irq_n` is high unless such a source is pending.
- R11: An `eoi` strobe clears `cur_valid`, so that any source still pending asserts `irq_n` again.
- R12: Source 0, disabled sources and excluded sources never assert `irq_n` and never win a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Raw request inputs, one bit per source number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | Write target: 0 selects the mode, 1 selects the vector word |
| cfg_idx | input | 5 | Source number being written |
| cfg_wdata | input | 32 | Write data |
| vec_rd | input | 1 | Vector read strobe; selects the winner and acknowledges it |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_n | output | 1 | Active-low interrupt request to the processor |
| vec_data | output | 32 | Vector word returned by the last read |
| cur_valid | output | 1 | An interrupt is current |
| cur_src | output | 5 | Number of the current source |
| cur_prio | output | 3 | Priority of the current source |

## Verification
A latched edge request that is not cleared on acknowledge shows at the ports as `irq_n` staying low one cycle after an end-of-interrupt strobe. A wrong priority compare or a wrong tie rule shows up in the next `vec_data` word, one edge after the read. A threshold that is not applied while an interrupt is current shows as `irq_n` asserting for an equal-priority source within three edges. Mistimed input registers move the `irq_n` fall away from the second or third edge, so the timing checks report them at once.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  // Field order is the write layout: enable at bit 5 down to priority at 2:0.
  typedef struct packed {
    logic              enable;
    logic              exclude;
    trig_e             trig;
    logic [PRIO_W-1:0] prio;
  } src_mode_t;

  localparam int MODE_W = $bits(src_mode_t);
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import irq_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  src_i,
  input  trig_e trig,
  input  logic  ack_clr,
  output logic  pend_o
);
  logic s_q, s_qq, edge_pend;
  logic rise_w;

  assign rise_w = s_q & ~s_qq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q       <= 1'b0;
      s_qq      <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      s_q  <= src_i;
      s_qq <= s_q;
      // A new edge arriving together with the acknowledge is kept.
      if (rise_w)       edge_pend <= 1'b1;
      else if (ack_clr) edge_pend <= 1'b0;
    end
  end

  assign pend_o = (trig == TRIG_EDGE) ? edge_pend : s_q;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [IDX_W-1:0]               idx,
  output logic [PRIO_W-1:0]              best
);
  // Scans from the top number downward; ">=" lets a lower number take a tie.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (elig[i] && (!found || prio[i] >= best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int           NUM_SRC     = 32,
  parameter int           VEC_W       = 32,
  parameter logic [31:0]  DEFAULT_VEC = 32'hFFFF_0000,
  localparam int          IDX_W       = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we,
  input  logic               cfg_kind,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [VEC_W-1:0]   cfg_wdata,
  input  logic               vec_rd,
  input  logic               eoi,
  output logic               irq_n,
  output logic [VEC_W-1:0]   vec_data,
  output logic               cur_valid,
  output logic [IDX_W-1:0]   cur_src,
  output logic [PRIO_W-1:0]  cur_prio
);
  src_mode_t                      mode_q [NUM_SRC];
  logic [VEC_W-1:0]               vec_q  [NUM_SRC];
  logic [NUM_SRC-1:0]             pend_w, elig_w, ack_w;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;

  // Named internal events used by the checker.
  logic              win_found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              raise_w;
  logic              take_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_kind) vec_q[cfg_idx]  <= cfg_wdata;
      else          mode_q[cfg_idx] <= src_mode_t'(cfg_wdata[MODE_W-1:0]);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i[g]),
      .trig    (mode_q[g].trig),
      .ack_clr (ack_w[g]),
      .pend_o  (pend_w[g])
    );
    assign prio_w[g] = mode_q[g].prio;
    if (g == 0) begin : g_reserved
      assign elig_w[g] = 1'b0;
    end else begin : g_normal
      assign elig_w[g] = pend_w[g] & mode_q[g].enable & ~mode_q[g].exclude
                       & (!cur_valid || (mode_q[g].prio > cur_prio));
    end
    assign ack_w[g] = take_w && (win_idx == IDX_W'(g));
  end

  irq_prio_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .elig  (elig_w),
    .prio  (prio_w),
    .found (win_found),
    .idx   (win_idx),
    .best  (win_prio)
  );

  assign raise_w = |elig_w;
  assign take_w  = vec_rd && win_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n     <= 1'b1;
      vec_data  <= VEC_W'(DEFAULT_VEC);
      cur_valid <= 1'b0;
      cur_src   <= '0;
      cur_prio  <= '0;
    end else begin
      irq_n <= ~raise_w;
      if (vec_rd) vec_data <= win_found ? vec_q[win_idx] : VEC_W'(DEFAULT_VEC);
      if (take_w) begin
        cur_valid <= 1'b1;
        cur_src   <= win_idx;
        cur_prio  <= win_prio;
      end else if (eoi) begin
        cur_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
  parameter int          IDX_W       = 5,
  parameter int          VEC_W       = 32,
  parameter logic [31:0] DEFAULT_VEC = 32'hFFFF_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vec_rd,
  input logic             eoi,
  input logic             irq_n,
  input logic [VEC_W-1:0] vec_data,
  input logic             cur_valid,
  input logic [IDX_W-1:0] cur_src,
  input logic [2:0]       cur_prio,
  input logic             win_found,
  input logic [IDX_W-1:0] win_idx,
  input logic [2:0]       win_prio
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_n && !cur_valid));

  p_ack_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && win_found) |=>
      (cur_valid && cur_src == $past(win_idx) && cur_prio == $past(win_prio)));

  p_empty_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !win_found) |=> (vec_data == VEC_W'(DEFAULT_VEC)));

  p_empty_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !win_found && !eoi) |=> $stable(cur_valid));

  p_preempt_higher_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && win_found && cur_valid) |-> (win_prio > cur_prio));

  p_eoi_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !vec_rd) |=> !cur_valid);

  p_src0_never_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> (cur_src != '0));
endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(
  .IDX_W(IDX_W), .VEC_W(VEC_W), .DEFAULT_VEC(DEFAULT_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .eoi(eoi), .irq_n(irq_n),
  .vec_data(vec_data), .cur_valid(cur_valid), .cur_src(cur_src),
  .cur_prio(cur_prio), .win_found(win_found), .win_idx(win_idx),
  .win_prio(win_prio)
);

// File: tb/irq_vec_arbiter_bench.sv
module irq_vec_arbiter_bench;
  localparam logic [31:0] EXP_DEFAULT = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        cfg_we, cfg_kind, vec_rd, eoi;
  logic [4:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        irq_n, cur_valid;
  logic [31:0] vec_data;
  logic [4:0]  cur_src;
  logic [2:0]  cur_prio;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_vec_arbiter u_irq_vec_arbiter (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .vec_rd(vec_rd), .eoi(eoi), .irq_n(irq_n), .vec_data(vec_data),
    .cur_valid(cur_valid), .cur_src(cur_src), .cur_prio(cur_prio)
  );

  function automatic logic [31:0] vec_of(input int n);
    return 32'hA000_0000 | (n << 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int n, input bit en, input bit excl,
                          input bit edg, input int pr);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 0; cfg_idx = 5'(n);
    cfg_wdata = {26'b0, en, excl, edg, 3'(pr)};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk);
    vec_rd = 1;
    @(negedge clk);
    vec_rd = 0;
    v = vec_data;
  endtask

  task automatic pulse_eoi();
    @(negedge clk);
    eoi = 1;
    @(negedge clk);
    eoi = 0;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; src_i = '0; cfg_we = 0; cfg_kind = 0; cfg_idx = '0;
    cfg_wdata = '0; vec_rd = 0; eoi = 0;
    edges(3);
    rst_n = 1;
    for (int n = 0; n < 32; n++) begin
      cfg_we = 1; cfg_kind = 1; cfg_idx = 5'(n); cfg_wdata = vec_of(n);
      @(negedge clk);
    end
    cfg_we = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0; src_i = '0; vec_rd = 0; eoi = 0; cfg_we = 0;
    edges(2);
    check(irq_n === 1'b1, "R1 irq_n in reset", 32'(irq_n), 32'd1);
    check(cur_valid === 1'b0, "R1 cur_valid in reset", 32'(cur_valid), 32'd0);
    rst_n = 1;
    edges(1);
    check(vec_data === EXP_DEFAULT, "R1 vec_data after reset", vec_data, EXP_DEFAULT);
    check(irq_n === 1'b1, "R1 irq_n after reset", 32'(irq_n), 32'd1);
  endtask

  task automatic t_level_latency();
    logic [31:0] v;
    reset_dut();
    set_mode(5, 1, 0, 0, 2);
    src_i[5] = 1;
    edges(1);
    check(irq_n === 1'b1, "R3 level irq_n after edge 1", 32'(irq_n), 32'd1);
    edges(1);
    check(irq_n === 1'b0, "R3 level irq_n after edge 2", 32'(irq_n), 32'd0);
    do_read(v);
    check(v === vec_of(5), "R5 level vector", v, vec_of(5));
    edges(1);
    check(irq_n === 1'b1, "R10 line drops while current", 32'(irq_n), 32'd1);
    src_i[5] = 0;
  endtask

  task automatic t_edge_latency();
    logic [31:0] v;
    reset_dut();
    set_mode(7, 1, 0, 1, 3);
    src_i[7] = 1;
    edges(1);
    src_i[7] = 0;
    edges(1);
    check(irq_n === 1'b1, "R4 edge irq_n after edge 2", 32'(irq_n), 32'd1);
    edges(1);
    check(irq_n === 1'b0, "R4 edge irq_n after edge 3", 32'(irq_n), 32'd0);
    edges(3);
    check(irq_n === 1'b0, "R4 edge request held", 32'(irq_n), 32'd0);
    do_read(v);
    check(v === vec_of(7), "R4 edge vector", v, vec_of(7));
    check(cur_valid && cur_src == 5'd7, "R8 cur_src", 32'(cur_src), 32'd7);
    check(cur_prio === 3'd3, "R8 cur_prio", 32'(cur_prio), 32'd3);
    pulse_eoi();
    check(cur_valid === 1'b0, "R11 eoi clears current", 32'(cur_valid), 32'd0);
    edges(1);
    check(irq_n === 1'b1, "R8 edge latch cleared by ack", 32'(irq_n), 32'd1);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    reset_dut();
    set_mode(3, 1, 0, 0, 1);
    set_mode(9, 1, 0, 0, 6);
    set_mode(20, 1, 0, 0, 4);
    src_i[3] = 1; src_i[9] = 1; src_i[20] = 1;
    edges(3);
    do_read(v);
    check(v === vec_of(9), "R5/R2 highest priority wins", v, vec_of(9));
    src_i = '0;
  endtask

  task automatic t_tie();
    logic [31:0] v;
    reset_dut();
    set_mode(25, 1, 0, 0, 5);
    set_mode(12, 1, 0, 0, 5);
    set_mode(4, 1, 0, 0, 5);
    src_i[25] = 1; src_i[12] = 1; src_i[4] = 1;
    edges(3);
    do_read(v);
    check(v === vec_of(4), "R6 tie to lowest number", v, vec_of(4));
    src_i = '0;
  endtask

  task automatic t_late();
    logic [31:0] v;
    reset_dut();
    set_mode(10, 1, 0, 0, 1);
    set_mode(30, 1, 0, 0, 7);
    src_i[10] = 1;
    edges(2);
    check(irq_n === 1'b0, "R7 line asserted by first source", 32'(irq_n), 32'd0);
    src_i[30] = 1;
    edges(2);
    do_read(v);
    check(v === vec_of(30), "R7 late source included", v, vec_of(30));
    src_i = '0;
  endtask

  task automatic t_empty();
    logic [31:0] v;
    reset_dut();
    do_read(v);
    check(v === EXP_DEFAULT, "R9 empty read default", v, EXP_DEFAULT);
    check(cur_valid === 1'b0, "R9 empty read no ack", 32'(cur_valid), 32'd0);
  endtask

  task automatic t_nest();
    logic [31:0] v;
    reset_dut();
    set_mode(6, 1, 0, 0, 2);
    set_mode(15, 1, 0, 0, 2);
    set_mode(16, 1, 0, 0, 5);
    src_i[6] = 1;
    edges(3);
    do_read(v);
    src_i[15] = 1;
    edges(3);
    check(irq_n === 1'b1, "R10 equal priority held off", 32'(irq_n), 32'd1);
    src_i[16] = 1;
    edges(2);
    check(irq_n === 1'b0, "R10 higher priority asserts", 32'(irq_n), 32'd0);
    do_read(v);
    check(v === vec_of(16), "R10 higher priority vector", v, vec_of(16));
    check(cur_prio === 3'd5, "R10 new current priority", 32'(cur_prio), 32'd5);
    src_i = '0;
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    reset_dut();
    set_mode(8, 1, 0, 0, 3);
    src_i[8] = 1;
    edges(3);
    do_read(v);
    edges(1);
    check(irq_n === 1'b1, "R11 line high while current", 32'(irq_n), 32'd1);
    pulse_eoi();
    edges(1);
    check(irq_n === 1'b0, "R11 line reasserts after eoi", 32'(irq_n), 32'd0);
    src_i = '0;
  endtask

  task automatic t_blocked();
    logic [31:0] v;
    reset_dut();
    set_mode(0, 1, 0, 0, 7);
    set_mode(11, 0, 0, 0, 7);
    set_mode(13, 1, 1, 0, 7);
    src_i[0] = 1; src_i[11] = 1; src_i[13] = 1;
    edges(4);
    check(irq_n === 1'b1, "R12 blocked sources silent", 32'(irq_n), 32'd1);
    do_read(v);
    check(v === EXP_DEFAULT, "R12 blocked sources never win", v, EXP_DEFAULT);
    src_i = '0;
  endtask

  initial begin
    rst_n = 0; src_i = '0; cfg_we = 0; cfg_kind = 0; cfg_idx = '0;
    cfg_wdata = '0; vec_rd = 0; eoi = 0;
    t_reset();
    t_level_latency();
    t_edge_latency();
    t_priority();
    t_tie();
    t_late();
    t_empty();
    t_nest();
    t_eoi();
    t_blocked();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule